// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Engine

This block is the byte-level controller of a single-wire slave device that carries a 64-bit identity value. It sits above a bit-level interface, which detects bus reset pulses, recovers bits written by the master, and reports the start of each read slot. The engine gathers a one-byte command after every bus reset and then runs one of three functions. It can stream the identity out, it can take part in a tree search across many slaves sharing a wired-AND line, or it can switch the device to the fast bit rate.

The identity value comes in on a port, so the integrator can tie it to fuses, straps or a constant. The byte at bits 7:0 is the family code, bits 55:8 are the serial number, and bits 63:56 are a CRC over the lower 56 bits. The engine does not interpret these fields. The read output gives the level the slave drives during the next read slot: 0 pulls the line low and 1 releases it. The overdrive output tells the bit layer which slot timing to apply.

Top module: `owrom_engine`

## Requirements
- R1: After `rst`, the engine is idle. `rd_bit_o` is 1 and `od_o` is 0. Written bits are ignored until the first `bus_reset_i` pulse.
- R2: A `bus_reset_i` pulse starts command collection. The next eight written bits form the command byte, with the first bit as bit 0.
- R3: Command 8'h33 selects identity read, 8'hF0 selects search and 8'h3C selects overdrive. Any other byte leaves the engine idle until the next bus reset: read slots return 1 and written bits, including a later valid code, are ignored.
- R4: During identity read, read slot k (k = 0..63) returns `rom_i[k]`. Written bits do not disturb the sequence.
- R5: During search, each identity bit k is handled as a triplet. The first read slot returns `rom_i[k]`, the second returns its complement, and a written bit then selects the branch.
- R6: If the selected bit differs from `rom_i[k]`, the engine drops out. Every later read slot returns 1 until the next bus reset.
- R7: The overdrive command sets `od_o`. A `bus_reset_i` pulse with `reset_long_i` low keeps it set. `od_o` clears only on a `bus_reset_i` pulse with `reset_long_i` high.
- R8: After the 64th read slot of identity read, or the 64th matching triplet of search, the engine goes idle and read slots return 1.
- R9: A `bus_reset_i` pulse during any phase abandons the current command. It clears the bit and byte counters and restarts command collection, and `rd_bit_o` is 1 in the next cycle.
- R10: While a command is being collected, and while a search triplet waits for its written bit, `rd_bit_o` is 1. An extra read slot in the write position does not advance the triplet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle pulse: bit layer saw a bus reset |
| reset_long_i | input | 1 | Qualifies `bus_reset_i`: reset low lasted the standard-speed minimum |
| wr_valid_i | input | 1 | One-cycle pulse: a write slot delivered a bit |
| wr_bit_i | input | 1 | Value of the written bit |
| rd_slot_i | input | 1 | One-cycle pulse: a read slot has consumed `rd_bit_o` |
| rom_i | input | ROM_W | Identity value, family code in bits 7:0 |
| rd_bit_o | output | 1 | Level for the next read slot (0 = pull low, 1 = release) |
| od_o | output | 1 | Overdrive speed flag |

## Verification
The hardest states to reach are the edges of the search walk. One is a drop-out on a late identity bit. The other is a complete 64-triplet pass that must end in the idle state rather than wrap around. The stimulus reaches them by acting as the master, reading each true/complement pair and writing back either the device's own bit or its inverse at a chosen index. It also places an extra read slot in the write position of a triplet, and it issues bus resets part way through both a command byte and a data stream.

// File: rtl/owrom_pkg.sv
package owrom_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
    localparam logic [CMD_W-1:0] OP_FAST   = 8'h3C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_SEARCH
    } eng_state_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_PICK
    } srch_phase_e;

    typedef struct packed {
        logic             valid;
        logic [CMD_W-1:0] code;
    } cmd_evt_t;

    function automatic eng_state_e next_from_cmd(logic [CMD_W-1:0] code);
        case (code)
            OP_READ:   return ST_READ;
            OP_SEARCH: return ST_SEARCH;
            default:   return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/owrom_cmd_rx.sv
module owrom_cmd_rx
    import owrom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     en,
    input  logic     bit_in,
    output cmd_evt_t evt
);
    localparam int CNT_W = $clog2(CMD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CMD_W - 1);

    logic [CMD_W-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (en) begin
            sh_q  <= {bit_in, sh_q[CMD_W-1:1]};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_comb begin
        evt.valid = en && (cnt_q == LAST) && !clr;
        evt.code  = {bit_in, sh_q[CMD_W-1:1]};
    end
endmodule

// File: rtl/owrom_walker.sv
module owrom_walker
    import owrom_pkg::*;
#(
    parameter int ROM_W = 64,
    localparam int IDX_W = $clog2(ROM_W)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_reset,
    input  cmd_evt_t    evt,
    input  logic        rd_slot,
    input  logic        wr_valid,
    input  logic        wr_bit,
    input  logic        rom_bit,
    output eng_state_e  st,
    output srch_phase_e ph,
    output logic [IDX_W-1:0] idx,
    output logic        od_set
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROM_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            ph  <= PH_TRUE;
            idx <= '0;
        end else if (bus_reset) begin
            st  <= ST_CMD;
            ph  <= PH_TRUE;
            idx <= '0;
        end else begin
            case (st)
                ST_CMD: if (evt.valid) begin
                    st  <= next_from_cmd(evt.code);
                    ph  <= PH_TRUE;
                    idx <= '0;
                end
                ST_READ: if (rd_slot) begin
                    if (idx == LAST) st <= ST_IDLE;
                    idx <= idx + 1'b1;
                end
                ST_SEARCH: begin
                    case (ph)
                        PH_TRUE: if (rd_slot) ph <= PH_COMP;
                        PH_COMP: if (rd_slot) ph <= PH_PICK;
                        default: if (wr_valid) begin
                            ph <= PH_TRUE;
                            if (wr_bit != rom_bit || idx == LAST) st <= ST_IDLE;
                            idx <= idx + 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign od_set = (st == ST_CMD) && !bus_reset && evt.valid && (evt.code == OP_FAST);
endmodule

// File: rtl/owrom_speed.sv
module owrom_speed (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic od
);
    always_ff @(posedge clk) begin
        if (rst || clr) od <= 1'b0;
        else if (set)   od <= 1'b1;
    end
endmodule

// File: rtl/owrom_engine.sv
module owrom_engine
    import owrom_pkg::*;
#(
    parameter int ROM_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_reset_i,
    input  logic             reset_long_i,
    input  logic             wr_valid_i,
    input  logic             wr_bit_i,
    input  logic             rd_slot_i,
    input  logic [ROM_W-1:0] rom_i,
    output logic             rd_bit_o,
    output logic             od_o
);
    localparam int IDX_W = $clog2(ROM_W);

    eng_state_e       st;
    srch_phase_e      ph;
    logic [IDX_W-1:0] idx;
    cmd_evt_t         evt;
    logic             od_set;
    logic             rom_bit;

    assign rom_bit = rom_i[idx];

    owrom_cmd_rx u_cmd (
        .clk    (clk),
        .rst    (rst),
        .clr    (bus_reset_i),
        .en     ((st == ST_CMD) && wr_valid_i),
        .bit_in (wr_bit_i),
        .evt    (evt)
    );

    owrom_walker #(.ROM_W(ROM_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset_i),
        .evt       (evt),
        .rd_slot   (rd_slot_i),
        .wr_valid  (wr_valid_i),
        .wr_bit    (wr_bit_i),
        .rom_bit   (rom_bit),
        .st        (st),
        .ph        (ph),
        .idx       (idx),
        .od_set    (od_set)
    );

    owrom_speed u_spd (
        .clk (clk),
        .rst (rst),
        .set (od_set),
        .clr (bus_reset_i && reset_long_i),
        .od  (od_o)
    );

    always_comb begin
        rd_bit_o = 1'b1;
        if (st == ST_READ) rd_bit_o = rom_bit;
        else if (st == ST_SEARCH) begin
            if (ph == PH_TRUE)      rd_bit_o = rom_bit;
            else if (ph == PH_COMP) rd_bit_o = ~rom_bit;
        end
    end
endmodule

// File: rtl/owrom_engine_chk.sv
module owrom_engine_chk
    import owrom_pkg::*;
#(
    parameter int ROM_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_reset_i,
    input logic             reset_long_i,
    input logic             wr_valid_i,
    input logic             rd_slot_i,
    input logic [ROM_W-1:0] rom_i,
    input logic             rd_bit_o,
    input logic             od_o,
    input eng_state_e       st,
    input srch_phase_e      ph
);
    // R7
    od_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_reset_i && reset_long_i) |=> !od_o);

    // R7
    od_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (od_o && !(bus_reset_i && reset_long_i)) |=> od_o);

    // R3
    od_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(od_o) |-> $past(wr_valid_i));

    // R9
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset_i |=> rd_bit_o);

    // R5
    triplet_comp_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SEARCH && ph == PH_TRUE && rd_slot_i && !bus_reset_i)
        |=> (rom_i != $past(rom_i)) || (rd_bit_o != $past(rd_bit_o)));

    // R10
    cmd_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CMD) |-> rd_bit_o);
endmodule

bind owrom_engine owrom_engine_chk #(.ROM_W(ROM_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_reset_i  (bus_reset_i),
    .reset_long_i (reset_long_i),
    .wr_valid_i   (wr_valid_i),
    .rd_slot_i    (rd_slot_i),
    .rom_i        (rom_i),
    .rd_bit_o     (rd_bit_o),
    .od_o         (od_o),
    .st           (st),
    .ph           (ph)
);

// File: tb/owrom_engine_tb_top.sv
module owrom_engine_tb_top;
    localparam int CLK_P = 10;
    localparam int ROM_W = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset_i = 1'b0, reset_long_i = 1'b0;
    logic wr_valid_i = 1'b0, wr_bit_i = 1'b0, rd_slot_i = 1'b0;
    logic [ROM_W-1:0] rom_i;
    logic rd_bit_o, od_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    owrom_engine #(.ROM_W(ROM_W)) dut_i (
        .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i), .reset_long_i(reset_long_i),
        .wr_valid_i(wr_valid_i), .wr_bit_i(wr_bit_i), .rd_slot_i(rd_slot_i),
        .rom_i(rom_i), .rd_bit_o(rd_bit_o), .od_o(od_o)
    );

    function automatic logic [7:0] crc_low56(logic [55:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 56; i++) begin
            logic fb = c[0] ^ d[i];
            c = c >> 1;
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_rst(input logic long_q);
        @(negedge clk); bus_reset_i = 1'b1; reset_long_i = long_q;
        @(negedge clk); bus_reset_i = 1'b0; reset_long_i = 1'b0;
    endtask

    task automatic wr_bit(input logic b);
        @(negedge clk); wr_valid_i = 1'b1; wr_bit_i = b;
        @(negedge clk); wr_valid_i = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr_bit(v[i]);
    endtask

    task automatic rd_slot(output logic b);
        @(negedge clk); b = rd_bit_o; rd_slot_i = 1'b1;
        @(negedge clk); rd_slot_i = 1'b0;
    endtask

    task automatic t_reset_state();
        logic b;
        check(rd_bit_o === 1'b1, "R1 idle line", {7'd0, rd_bit_o}, 8'd1);
        check(od_o === 1'b0, "R1 od clear", {7'd0, od_o}, 8'd0);
        wr_byte(8'h33);
        rd_slot(b);
        check(b === 1'b1, "R1 no cmd before bus reset", {7'd0, b}, 8'd1);
    endtask

    task automatic t_read_rom();
        logic b;
        int bad = 0;
        bus_rst(1'b1);
        wr_byte(8'h33);
        for (int k = 0; k < ROM_W; k++) begin
            rd_slot(b);
            if (k == 20) wr_bit(~rom_i[21]);
            if (b !== rom_i[k]) begin
                bad++;
                check(1'b0, "R4 read bit", {7'd0, b}, {7'd0, rom_i[k]});
            end
        end
        check(bad == 0, "R2 R4 read stream", 8'(bad), 8'd0);
        rd_slot(b);
        check(b === 1'b1, "R8 idle after read", {7'd0, b}, 8'd1);
    endtask

    task automatic t_search(input int drop_at);
        logic t, c, b;
        int bad = 0;
        bus_rst(1'b1);
        wr_byte(8'hF0);
        for (int k = 0; k < ROM_W; k++) begin
            rd_slot(t);
            rd_slot(c);
            if (t !== rom_i[k] || c !== ~rom_i[k]) bad++;
            if (k == 3) begin
                rd_slot(b);
                check(b === 1'b1, "R10 pick slot releases", {7'd0, b}, 8'd1);
            end
            if (k == drop_at) begin
                wr_bit(~rom_i[k]);
                rd_slot(t); rd_slot(c);
                check(t === 1'b1 && c === 1'b1, "R6 dropped out releases",
                      {6'd0, t, c}, 8'd3);
                wr_bit(rom_i[k + 1]);
                rd_slot(t);
                check(t === 1'b1, "R6 stays out", {7'd0, t}, 8'd1);
                break;
            end
            wr_bit(rom_i[k]);
        end
        check(bad == 0, "R5 triplet pairs", 8'(bad), 8'd0);
        if (drop_at >= ROM_W) begin
            rd_slot(b);
            check(b === 1'b1, "R8 idle after search", {7'd0, b}, 8'd1);
        end
    endtask

    task automatic t_unknown();
        logic b;
        bus_rst(1'b0);
        wr_byte(8'hA5);
        wr_byte(8'h33);
        rd_slot(b);
        check(b === 1'b1, "R3 unknown cmd idle", {7'd0, b}, 8'd1);
        check(od_o === 1'b0, "R3 unknown no od", {7'd0, od_o}, 8'd0);
    endtask

    task automatic t_overdrive();
        logic b;
        bus_rst(1'b1);
        wr_byte(8'h3C);
        check(od_o === 1'b1, "R7 od set", {7'd0, od_o}, 8'd1);
        bus_rst(1'b0);
        check(od_o === 1'b1, "R7 short reset keeps od", {7'd0, od_o}, 8'd1);
        wr_byte(8'h33);
        rd_slot(b);
        check(b === rom_i[0], "R3 read after od", {7'd0, b}, {7'd0, rom_i[0]});
        bus_rst(1'b1);
        check(od_o === 1'b0, "R7 long reset clears od", {7'd0, od_o}, 8'd0);
    endtask

    task automatic t_abort();
        logic b;
        bus_rst(1'b0);
        wr_byte(8'h33);
        for (int k = 0; k < 10; k++) rd_slot(b);
        bus_rst(1'b0);
        check(rd_bit_o === 1'b1, "R9 release after abort", {7'd0, rd_bit_o}, 8'd1);
        wr_bit(1'b1); wr_bit(1'b1); wr_bit(1'b0);
        bus_rst(1'b0);
        wr_byte(8'h33);
        rd_slot(b);
        check(b === rom_i[0], "R9 restart bit0", {7'd0, b}, {7'd0, rom_i[0]});
        rd_slot(b);
        check(b === rom_i[1], "R9 restart bit1", {7'd0, b}, {7'd0, rom_i[1]});
    endtask

    initial begin
        logic [55:0] low = {48'h5A3C_9E17_42D6, 8'h01};
        rom_i = {crc_low56(low), low};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_read_rom();
        t_search(ROM_W);
        t_search(5);
        t_search(40);
        t_unknown();
        t_overdrive();
        t_abort();
        rom_i = ~rom_i;
        t_read_rom();
        t_search(ROM_W);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule